// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block drives the column address bus of an SDRAM controller during a read or write burst. When the controller accepts a READ or WRITE command it pulses `start` with the starting column, the bank, the burst mode fields and the auto-precharge flag. From the next clock on, the block presents one column address per cycle. It stops when the programmed number of beats is done, when a terminate request arrives, or when a new start replaces the running burst.

Two column orders are available for bursts of 2, 4 and 8 beats. In sequential order the low address bits count upward. In interleaved order the low bits are the start bits XORed with the beat number. In both orders the address stays inside the aligned block that holds the start column. A full-page burst walks all 256 columns of the row and wraps. It runs until a terminate or a new start ends it.

The final beat of a burst is flagged. When the burst was issued with auto precharge, the block raises a one-cycle precharge request for its bank once the burst is over.

Top module: `burst_col_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `col_valid`, `col_last` and `pre_req` are low.
- R2: `start` is sampled on a rising edge, and `start_col`, `start_bank`, `mode_len`, `mode_ilv` and `auto_pre` are captured at that edge. In the next cycle `col_valid` is high and `col_addr` equals `start_col`.
- R3: `mode_len` selects the burst length: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives full page. The codes 3'b100, 3'b101 and 3'b110 give 1 beat.
- R4: Sequential order (`mode_ilv`=0), length L of 2, 4 or 8: beat k keeps the column bits above log2(L) from the start column, and its low log2(L) bits are (start low bits + k) mod L.
- R5: Interleaved order (`mode_ilv`=1), length L of 2, 4 or 8: beat k keeps the upper bits as in R4, and its low log2(L) bits are (start low bits XOR k).
- R6: A full-page burst ignores `mode_ilv`. Beat k is (start + k) mod 256. It never asserts `col_last` and continues until a terminate or a new start.
- R7: `col_last` is high exactly in the cycle that shows the final address of a 1, 2, 4 or 8 beat burst. In the next cycle `col_valid` is low unless a new burst was started.
- R8: `start` is honoured in every cycle, including during a running burst and in its last beat cycle. The next cycle shows beat 0 of the new burst, and the replaced burst raises no precharge request.
- R9: `term` sampled high during a burst, with `start` low, makes `col_valid` low in the next cycle. `term` while no burst runs has no effect, and `start` takes priority over `term`.
- R10: A burst captured with `auto_pre`=1 that ends by its last beat or by `term` raises `pre_req` for one cycle, with `pre_bank` equal to its captured bank. That cycle is the one after the last shown beat. With `auto_pre`=0 no request is raised.
- R11: Changes on `start_col`, `start_bank`, `mode_len`, `mode_ilv` and `auto_pre` while `start` is low do not alter the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load a new burst from the fields below |
| start_col | input | 8 | Starting column of the burst |
| start_bank | input | 2 | Bank of the burst, returned with the precharge request |
| mode_len | input | 3 | Burst length code (R3) |
| mode_ilv | input | 1 | 1 selects interleaved order, 0 sequential |
| auto_pre | input | 1 | Request precharge when the burst ends |
| term | input | 1 | End the running burst |
| col_valid | output | 1 | A burst beat is on `col_addr` |
| col_addr | output | 8 | Column address of the current beat |
| col_last | output | 1 | Current beat is the final one |
| pre_req | output | 1 | One-cycle precharge request |
| pre_bank | output | 2 | Bank for `pre_req` |

## Verification
The assertions assume that every input holds a known 0 or 1 at each sampling edge. They also assume the controller never expects a burst to run on after `col_last` without issuing a new start. The stimulus changes inputs only at falling edges and always drives defined values. Between starts it deliberately toggles the capture fields to junk values, which exercises R11 without ever leaving an input undriven.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    typedef enum logic [2:0] {
        BL_ONE  = 3'b000,
        BL_TWO  = 3'b001,
        BL_FOUR = 3'b010,
        BL_EIGHT= 3'b011,
        BL_PAGE = 3'b111
    } blen_e;

    localparam int LEN_CODE_W = 3;

endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [LEN_CODE_W-1:0] len_code,
    output logic [COL_W-1:0]      wrap_mask,
    output logic                  page_mode
);

    localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

    always_comb begin
        wrap_mask = '0;
        page_mode = 1'b0;
        case (blen_e'(len_code))
            BL_TWO:   wrap_mask = COL_W'(1);
            BL_FOUR:  wrap_mask = COL_W'(3);
            BL_EIGHT: wrap_mask = COL_W'(7);
            BL_PAGE: begin
                wrap_mask = ALL_ONES;
                page_mode = 1'b1;
            end
            default:  wrap_mask = '0;
        endcase
    end

endmodule

// File: rtl/bcg_addr_calc.sv
module bcg_addr_calc #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [COL_W-1:0] beat_num,
    input  logic [COL_W-1:0] wrap_mask,
    input  logic             xor_order,
    output logic [COL_W-1:0] col_out
);

    logic [COL_W-1:0] low_part;

    always_comb begin
        if (xor_order) begin
            low_part = base_col ^ beat_num;
        end else begin
            low_part = base_col + beat_num;
        end
        col_out = (base_col & ~wrap_mask) | (low_part & wrap_mask);
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int BANK_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [COL_W-1:0]      start_col,
    input  logic [BANK_W-1:0]     start_bank,
    input  logic [LEN_CODE_W-1:0] mode_len,
    input  logic                  mode_ilv,
    input  logic                  auto_pre,
    input  logic                  term,
    output logic                  col_valid,
    output logic [COL_W-1:0]      col_addr,
    output logic                  col_last,
    output logic                  pre_req,
    output logic [BANK_W-1:0]     pre_bank
);

    localparam logic [COL_W-1:0] BEAT_STEP = COL_W'(1);

    typedef struct packed {
        logic              busy;
        logic [COL_W-1:0]  base;
        logic [COL_W-1:0]  beat;
        logic [COL_W-1:0]  mask;
        logic              page;
        logic              xord;
        logic              apre;
        logic [BANK_W-1:0] bank;
        logic              pre;
    } gen_state_t;

    gen_state_t st_d, st_q;

    logic [COL_W-1:0] new_mask;
    logic             new_page;
    logic             final_beat;

    bcg_len_decode #(.COL_W(COL_W)) u_len (
        .len_code (mode_len),
        .wrap_mask(new_mask),
        .page_mode(new_page)
    );

    bcg_addr_calc #(.COL_W(COL_W)) u_calc (
        .base_col (st_q.base),
        .beat_num (st_q.beat),
        .wrap_mask(st_q.mask),
        .xor_order(st_q.xord),
        .col_out  (col_addr)
    );

    assign final_beat = st_q.busy && !st_q.page && (st_q.beat == st_q.mask);

    always_comb begin
        st_d     = st_q;
        st_d.pre = 1'b0;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.base = start_col;
            st_d.beat = '0;
            st_d.mask = new_mask;
            st_d.page = new_page;
            st_d.xord = mode_ilv & ~new_page;
            st_d.apre = auto_pre;
            st_d.bank = start_bank;
        end else if (st_q.busy && (term || final_beat)) begin
            st_d.busy = 1'b0;
            st_d.pre  = st_q.apre;
        end else if (st_q.busy) begin
            st_d.beat = st_q.beat + BEAT_STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col_valid = st_q.busy;
    assign col_last  = final_beat;
    assign pre_req   = st_q.pre;
    assign pre_bank  = st_q.bank;

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic             term,
    input logic             col_valid,
    input logic [COL_W-1:0] col_addr,
    input logic             col_last,
    input logic             pre_req
);

    a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (col_valid && col_addr == $past(start_col)));

    a_r7_last_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);

    a_r7_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && !start) |=> !col_valid);

    a_r9_term_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && term && !start) |=> !col_valid);

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_valid && !start) |=> !col_valid);

    a_r8_no_pre_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !pre_req);

    a_r10_pre_single: assert property (@(posedge clk) disable iff (!rst_n)
        pre_req |=> !pre_req);

    a_r10_pre_needs_end: assert property (@(posedge clk) disable iff (!rst_n)
        pre_req |-> !col_valid);

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .start_col(start_col),
    .term     (term),
    .col_valid(col_valid),
    .col_addr (col_addr),
    .col_last (col_last),
    .pre_req  (pre_req)
);

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] start_col = '0;
    logic [1:0] start_bank = '0;
    logic [2:0] mode_len = '0;
    logic       mode_ilv = 1'b0;
    logic       auto_pre = 1'b0;
    logic       term = 1'b0;
    logic       col_valid;
    logic [7:0] col_addr;
    logic       col_last;
    logic       pre_req;
    logic [1:0] pre_bank;

    always #5 clk = ~clk;

    burst_col_gen u_burst_col_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .start_bank(start_bank), .mode_len(mode_len), .mode_ilv(mode_ilv),
        .auto_pre(auto_pre), .term(term), .col_valid(col_valid),
        .col_addr(col_addr), .col_last(col_last), .pre_req(pre_req),
        .pre_bank(pre_bank)
    );

    typedef struct {
        logic       v;
        logic [7:0] a;
        logic       l;
        logic       p;
        logic [1:0] b;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    logic [7:0] junk = 8'h5A;

    // reference state built from the requirements
    logic m_act = 1'b0;
    int   m_base, m_beat, m_len;  // m_len 0 means full page
    logic m_ilv, m_ap, m_pre = 1'b0;
    logic [1:0] m_bank, m_pbank = '0;

    function automatic int len_of(input logic [2:0] code);
        case (code)
            3'b001: return 2;
            3'b010: return 4;
            3'b011: return 8;
            3'b111: return 0;
            default: return 1;
        endcase
    endfunction

    function automatic logic [7:0] ref_addr();
        int off, lo;
        if (m_len == 0) return 8'((m_base + m_beat) % 256);
        off = m_base % m_len;
        lo  = m_ilv ? (off ^ m_beat) : ((off + m_beat) % m_len);
        return 8'(m_base - off + lo);
    endfunction

    task automatic step(input logic st, input logic [7:0] col, input logic [1:0] bk,
                        input logic [2:0] ln, input logic il, input logic ap,
                        input logic tm, input string tag);
        logic cur_last;
        exp_t e;
        @(negedge clk);
        junk = junk * 8'd29 + 8'd7;
        start      = st;
        term       = tm;
        start_col  = st ? col : junk;
        start_bank = st ? bk : junk[1:0];
        mode_len   = st ? ln : junk[4:2];
        mode_ilv   = st ? il : junk[5];
        auto_pre   = st ? ap : junk[6];
        cur_last = m_act && m_len != 0 && m_beat == m_len - 1;
        m_pre = 1'b0;
        if (st) begin
            m_act = 1'b1; m_base = col; m_beat = 0; m_len = len_of(ln);
            m_ilv = il && (m_len != 0); m_ap = ap; m_bank = bk;
        end else if (m_act && (tm || cur_last)) begin
            m_act = 1'b0; m_pre = m_ap; m_pbank = m_bank;
        end else if (m_act) begin
            m_beat = (m_beat + 1) % 256;
        end
        e.v = m_act;
        e.a = m_act ? ref_addr() : 8'h00;
        e.l = m_act && m_len != 0 && m_beat == m_len - 1;
        e.p = m_pre;
        e.b = m_pbank;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic burst(input logic [7:0] col, input logic [1:0] bk, input logic [2:0] ln,
                         input logic il, input logic ap, input int n, input string tag);
        step(1'b1, col, bk, ln, il, ap, 1'b0, tag);
        idle(n - 1, tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (col_valid !== e.v || col_last !== e.l || pre_req !== e.p ||
                    (e.v && col_addr !== e.a) || (e.p && pre_bank !== e.b)) begin
                    n_bad++;
                    $display("FAIL %s: got v=%0b a=%02h l=%0b p=%0b b=%0d exp v=%0b a=%02h l=%0b p=%0b b=%0d",
                             t, col_valid, col_addr, col_last, pre_req, pre_bank,
                             e.v, e.a, e.l, e.p, e.b);
                end
            end
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // watchdog
    initial begin
        #1500000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got running exp finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (col_valid !== 1'b0 || col_last !== 1'b0 || pre_req !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: got v=%0b l=%0b p=%0b exp 0 0 0", col_valid, col_last, pre_req);
        end
        rst_n = 1'b1;
        idle(2, "R1");
        // R4 sequential 8 beats, R2 capture
        burst(8'h35, 2'd0, 3'b011, 1'b0, 1'b0, 10, "R4");
        // R5 interleaved 8 beats
        burst(8'h35, 2'd1, 3'b011, 1'b1, 1'b0, 10, "R5");
        burst(8'hAE, 2'd0, 3'b010, 1'b0, 1'b0, 6, "R4");
        burst(8'hAE, 2'd0, 3'b010, 1'b1, 1'b0, 6, "R5");
        burst(8'h11, 2'd0, 3'b001, 1'b1, 1'b0, 4, "R5");
        burst(8'h7F, 2'd0, 3'b000, 1'b1, 1'b0, 3, "R3");
        burst(8'h42, 2'd0, 3'b101, 1'b0, 1'b0, 3, "R3");
        burst(8'h42, 2'd0, 3'b110, 1'b0, 1'b0, 3, "R3");
        // R7 back to back bursts
        burst(8'h06, 2'd0, 3'b001, 1'b0, 1'b0, 2, "R7");
        burst(8'h07, 2'd0, 3'b001, 1'b0, 1'b0, 3, "R7");
        // R6 full page wrapping, interleave ignored, then R9 terminate with R10 request
        burst(8'hFD, 2'd2, 3'b111, 1'b1, 1'b1, 300, "R6");
        step(1'b0, 8'h00, 2'd0, 3'd0, 1'b0, 1'b0, 1'b1, "R9");
        idle(3, "R10");
        // R9 term while idle, term with start
        step(1'b0, 8'h00, 2'd0, 3'd0, 1'b0, 1'b0, 1'b1, "R9");
        step(1'b1, 8'h20, 2'd1, 3'b010, 1'b0, 1'b1, 1'b1, "R9");
        idle(6, "R9");
        // R10 auto precharge on last beat
        burst(8'h93, 2'd3, 3'b010, 1'b0, 1'b1, 7, "R10");
        burst(8'h93, 2'd1, 3'b000, 1'b0, 1'b1, 3, "R10");
        // R8 restart mid-burst; the replaced burst had auto precharge
        burst(8'h50, 2'd3, 3'b011, 1'b0, 1'b1, 3, "R8");
        burst(8'hC8, 2'd0, 3'b011, 1'b1, 1'b0, 10, "R8");
        // R8 restart in the last beat cycle
        burst(8'h10, 2'd2, 3'b001, 1'b0, 1'b1, 2, "R8");
        burst(8'h24, 2'd1, 3'b001, 1'b0, 1'b1, 4, "R8");
        // R11 junk on capture fields during a long burst
        burst(8'h08, 2'd1, 3'b111, 1'b0, 1'b0, 20, "R11");
        step(1'b0, 8'h00, 2'd0, 3'd0, 1'b0, 1'b0, 1'b1, "R11");
        idle(3, "R11");
        repeat (3) @(posedge clk);
        #3;
        finish_run();
    end

endmodule